// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block decides, row by row, when a DRAM bank needs a refresh. It does not refresh every row at the fastest rate. Rows are placed in retention classes, and a row that holds its charge well is refreshed less often. Membership in the two short-retention classes is kept in two small probabilistic bit arrays (Bloom filters). A profiling port writes these arrays. Each array can be wiped in one cycle, and a single row can never be taken out of it. When a filter reports a row that was never inserted, the only effect is an extra refresh. A refresh can never be skipped this way.

A periodic tick moves a row pointer through the bank. One full pass of the pointer is one base refresh period. A 2-bit pass counter numbers four passes in turn. Fast-class rows are refreshed on every pass, mid-class rows on every second pass, and all remaining rows once in four passes. A refresh that falls due is presented as a row address on a valid/ready port. The pointer does not move until that request is accepted. A tick that arrives while the block is busy is lost, and it sets a sticky overrun flag.

The control is a three-state machine:
- `ST_IDLE` waits for a tick and moves to `ST_LOOKUP`.
- `ST_LOOKUP` looks up the current row. It moves to `ST_ISSUE` when the row is due. Otherwise it advances the pointer and returns to `ST_IDLE`.
- `ST_ISSUE` holds the request. When `rq_ready` is high it advances the pointer and returns to `ST_IDLE`.

Top module: `rrs_refresh_sched`

## Requirements
- R1: After reset, `rq_valid` and `overrun` are 0, the row pointer is 0 and the pass counter is 0.
- R2: A profiling insert with `prof_ins`=1 sets two bits in the filter chosen by `prof_bin` (0 = fast class, 1 = mid class). The bit indices are h0 = (row*37+11) mod 256 and h1 = (row*101+59) mod 256, where row is the zero-extended row address.
- R3: A row is a member of a filter only when both of its indexed bits are set in that filter.
- R4: For the current pass count s (0..3), a refresh is due for a row in one of these cases: it is a fast-class member; it is a mid-class member and s is even; or s is 0. A row in both filters follows the fast class.
- R5: A tick sampled in `ST_IDLE` makes `rq_valid` rise on the second rising edge after it, when the row is due. `rq_valid` stays 0 after the first of those edges.
- R6: While `rq_valid` is 1 and `rq_ready` is 0, `rq_valid` and `rq_row` hold their values. The request completes on an edge where `rq_ready` is 1, and `rq_valid` is 0 after that edge.
- R7: Each accepted tick looks up the current row. The row pointer then moves up by one, after the handshake if the row was due. It wraps from the last row to 0, and the pass counter moves up by one (mod 4) at each wrap.
- R8: A tick that arrives outside `ST_IDLE` is dropped, which means the row pointer does not move. It sets `overrun`, and `overrun` stays 1 until reset.
- R9: `prof_clr`=1 clears every bit of the filter chosen by `prof_bin` in one cycle. If an insert to the same filter happens in the same cycle, the clear wins.
- R10: A profiling write affects every lookup made after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse that steps the row pointer |
| prof_ins | input | 1 | Insert `prof_row` into the selected filter |
| prof_clr | input | 1 | Clear the selected filter |
| prof_bin | input | 1 | Filter select: 0 fast class, 1 mid class |
| prof_row | input | ROW_W | Row address for insert |
| rq_valid | output | 1 | Refresh request pending |
| rq_ready | input | 1 | Downstream accepts the request |
| rq_row | output | ROW_W | Row to refresh |
| overrun | output | 1 | Sticky: a tick was lost while the block was busy |

## Verification
The bench runs four full passes with rows in the fast class, in the mid class and in both. A design that mixed up the even/odd pass rule, or let the mid class override the fast class, would then skip or add requests on odd passes.

It holds off `rq_ready` and sends a tick during the stall. A design that moved the pointer, changed `rq_row` or counted the lost tick would then present the wrong row later.

It also issues a clear and an insert to the same filter in one cycle, and inserts a row partway through a pass. A design that gave the insert priority, or delayed the write, would then refresh the affected rows at the wrong rate.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    localparam int unsigned NUM_BINS  = 2;
    localparam int unsigned SWEEP_W   = 2;
    localparam int unsigned HASH0_MUL = 37;
    localparam int unsigned HASH0_ADD = 11;
    localparam int unsigned HASH1_MUL = 101;
    localparam int unsigned HASH1_ADD = 59;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_ISSUE  = 2'd2
    } rrs_state_e;
endpackage

// File: rtl/rrs_bloom.sv
module rrs_bloom #(
    parameter int ROW_W = 6,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins,
    input  logic             clr,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [ROW_W-1:0] rd_row,
    output logic             hit
);
    import rrs_pkg::*;

    localparam int NBITS = 1 << IDX_W;

    function automatic logic [IDX_W-1:0] hidx(input logic [ROW_W-1:0] r,
                                              input int unsigned mul,
                                              input int unsigned add);
        return IDX_W'(32'(r) * mul + add);
    endfunction

    logic [NBITS-1:0] bits_q;
    logic [IDX_W-1:0] wa0, wa1, ra0, ra1;

    always_comb begin
        wa0 = hidx(wr_row, HASH0_MUL, HASH0_ADD);
        wa1 = hidx(wr_row, HASH1_MUL, HASH1_ADD);
        ra0 = hidx(rd_row, HASH0_MUL, HASH0_ADD);
        ra1 = hidx(rd_row, HASH1_MUL, HASH1_ADD);
    end

    // clear has priority; bits are only ever set otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (clr) begin
            bits_q <= '0;
        end else if (ins) begin
            bits_q[wa0] <= 1'b1;
            bits_q[wa1] <= 1'b1;
        end
    end

    always_comb hit = bits_q[ra0] & bits_q[ra1];
endmodule

// File: rtl/rrs_sweep.sv
module rrs_sweep #(
    parameter int ROW_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step,
    output logic [ROW_W-1:0]            row,
    output logic [rrs_pkg::SWEEP_W-1:0] sweep
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row   <= '0;
            sweep <= '0;
        end else if (step) begin
            row <= row + 1'b1;
            if (row == '1) begin
                sweep <= sweep + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rrs_rate_sel.sv
module rrs_rate_sel (
    input  logic                        hit_fast,
    input  logic                        hit_mid,
    input  logic [rrs_pkg::SWEEP_W-1:0] sweep,
    output logic                        due
);
    logic pass_zero, pass_even;

    always_comb begin
        pass_zero = (sweep == '0);
        pass_even = ~sweep[0];
        // fast class dominates; mid on even passes; the rest on pass 0
        due = hit_fast | (hit_mid & pass_even) | pass_zero;
    end
endmodule

// File: rtl/rrs_refresh_sched.sv
module rrs_refresh_sched #(
    parameter int ROW_W = 6,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             prof_ins,
    input  logic             prof_clr,
    input  logic             prof_bin,
    input  logic [ROW_W-1:0] prof_row,
    output logic             rq_valid,
    input  logic             rq_ready,
    output logic [ROW_W-1:0] rq_row,
    output logic             overrun
);
    import rrs_pkg::*;

    rrs_state_e          state_q, state_d;
    logic [ROW_W-1:0]    cur_row;
    logic [SWEEP_W-1:0]  sweep;
    logic [NUM_BINS-1:0] hit;
    logic                due;
    logic                step;
    logic                overrun_q;

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
        logic sel;
        assign sel = (prof_bin == 1'(g));
        rrs_bloom #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ins    (prof_ins & sel),
            .clr    (prof_clr & sel),
            .wr_row (prof_row),
            .rd_row (cur_row),
            .hit    (hit[g])
        );
    end

    rrs_rate_sel u_rate (
        .hit_fast (hit[0]),
        .hit_mid  (hit[1]),
        .sweep    (sweep),
        .due      (due)
    );

    rrs_sweep #(.ROW_W(ROW_W)) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .row   (cur_row),
        .sweep (sweep)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (due) begin
                    state_d = ST_ISSUE;
                end else begin
                    state_d = ST_IDLE;
                    step    = 1'b1;
                end
            end
            ST_ISSUE: begin
                if (rq_ready) begin
                    state_d = ST_IDLE;
                    step    = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // sticky lost-tick flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           overrun_q <= 1'b0;
        else if (tick && state_q != ST_IDLE)  overrun_q <= 1'b1;
    end

    // outputs
    always_comb begin
        rq_valid = (state_q == ST_ISSUE);
        rq_row   = cur_row;
        overrun  = overrun_q;
    end
endmodule

// File: rtl/rrs_refresh_sched_chk.sv
module rrs_refresh_sched_chk #(
    parameter int ROW_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             rq_valid,
    input logic             rq_ready,
    input logic [ROW_W-1:0] rq_row,
    input logic             overrun
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!rq_valid && !overrun));

    assert_req_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rq_valid) |-> $past(tick, 2));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_row)));

    assert_accept_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && rq_ready) |=> !rq_valid);

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rq_valid) |=> overrun);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind rrs_refresh_sched rrs_refresh_sched_chk #(.ROW_W(ROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rq_valid (rq_valid),
    .rq_ready (rq_ready),
    .rq_row   (rq_row),
    .overrun  (overrun)
);

// File: tb/tb_rrs_refresh_sched.sv
`timescale 1ns/1ps
module tb_rrs_refresh_sched;
    localparam int ROW_W = 6;
    localparam int NROWS = 1 << ROW_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             prof_ins = 1'b0;
    logic             prof_clr = 1'b0;
    logic             prof_bin = 1'b0;
    logic [ROW_W-1:0] prof_row = '0;
    logic             rq_valid;
    logic             rq_ready = 1'b0;
    logic [ROW_W-1:0] rq_row;
    logic             overrun;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [255:0] fa = '0;
    logic [255:0] fb = '0;
    int mrow = 0;
    int msweep = 0;

    always #10 clk = ~clk;

    rrs_refresh_sched #(.ROW_W(ROW_W), .IDX_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .prof_ins(prof_ins),
        .prof_clr(prof_clr), .prof_bin(prof_bin), .prof_row(prof_row),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_row(rq_row),
        .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit member(input logic [255:0] f, input int r);
        return f[(r * 37 + 11) % 256] && f[(r * 101 + 59) % 256];
    endfunction

    function automatic bit model_due();
        bit a, b;
        a = member(fa, mrow);
        b = member(fb, mrow);
        return a || (b && (msweep % 2 == 0)) || (msweep == 0);
    endfunction

    function automatic void model_step();
        mrow = (mrow + 1) % NROWS;
        if (mrow == 0) msweep = (msweep + 1) % 4;
    endfunction

    // R2, R10: insert a row into a filter
    task automatic prof_insert(input bit bin, input int r);
        @(negedge clk);
        prof_ins = 1'b1; prof_bin = bin; prof_row = ROW_W'(r);
        @(negedge clk);
        prof_ins = 1'b0;
        if (bin) begin fb[(r*37+11)%256] = 1'b1; fb[(r*101+59)%256] = 1'b1; end
        else     begin fa[(r*37+11)%256] = 1'b1; fa[(r*101+59)%256] = 1'b1; end
    endtask

    // R9: clear, optionally with a simultaneous insert to the same filter
    task automatic prof_clear(input bit bin, input bit with_ins, input int r);
        @(negedge clk);
        prof_clr = 1'b1; prof_ins = with_ins; prof_bin = bin; prof_row = ROW_W'(r);
        @(negedge clk);
        prof_clr = 1'b0; prof_ins = 1'b0;
        if (bin) fb = '0; else fa = '0;
    endtask

    // one tick with immediate acceptance; checks R3, R4, R5, R6, R7
    task automatic tick_one();
        bit exp_due;
        exp_due = model_due();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk(rq_valid == 1'b0, "R5 no request after first edge", int'(rq_valid), 0);
        @(negedge clk);
        chk(rq_valid == exp_due, $sformatf("R4 due row=%0d pass=%0d", mrow, msweep),
            int'(rq_valid), int'(exp_due));
        if (exp_due) begin
            chk(rq_row == ROW_W'(mrow), "R7 requested row", int'(rq_row), mrow);
            rq_ready = 1'b1;
            @(negedge clk); rq_ready = 1'b0;
            chk(rq_valid == 1'b0, "R6 request drops after accept", int'(rq_valid), 0);
        end
        model_step();
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) tick_one();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rq_valid == 1'b0, "R1 reset valid", int'(rq_valid), 0);
        chk(overrun == 1'b0, "R1 reset overrun", int'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rq_row == '0, "R1 reset row", int'(rq_row), 0);
    endtask

    // four full passes with rows in each class
    task automatic t_classes();
        prof_insert(1'b0, 3);
        prof_insert(1'b0, 17);
        prof_insert(1'b1, 5);
        prof_insert(1'b1, 40);
        prof_insert(1'b0, 9);
        prof_insert(1'b1, 9);   // both classes: fast wins (R4)
        run_ticks(4 * NROWS);   // R7 wraps back to pass 0
    endtask

    // stalled downstream and a lost tick: R6, R8
    task automatic t_stall();
        int hold_row;
        hold_row = mrow;        // pass 0: every row is due
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        chk(rq_valid == 1'b1, "R5 request pending", int'(rq_valid), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(rq_valid == 1'b1 && rq_row == ROW_W'(hold_row), "R6 held during stall",
                int'(rq_row), hold_row);
        end
        chk(overrun == 1'b0, "R8 no overrun yet", int'(overrun), 0);
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
        chk(rq_row == ROW_W'(hold_row), "R8 dropped tick keeps row", int'(rq_row), hold_row);
        rq_ready = 1'b1;
        @(negedge clk); rq_ready = 1'b0;
        chk(rq_valid == 1'b0, "R6 accept after stall", int'(rq_valid), 0);
        model_step();
        tick_one();             // the next row, not two rows on
        chk(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);
    endtask

    // clear priority and mid-pass insertion: R9, R10
    task automatic t_clear();
        prof_clear(1'b0, 1'b1, 33);   // clear wins over insert of row 33
        run_ticks(NROWS - mrow);      // now at pass 1, row 0
        chk(msweep == 1, "R7 pass index", msweep, 1);
        run_ticks(10);                // past rows 3 and 9: no longer fast
        prof_insert(1'b0, 20);        // R10 takes effect for row 20 this pass
        run_ticks(NROWS - mrow);      // covers rows 20 and 33
        run_ticks(NROWS);             // pass 2 then pass 3 partly
        run_ticks(30);
    endtask

    initial begin
        t_reset();
        t_classes();
        t_stall();
        t_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule